// File: doc/BRIEF.md
# Clock Output Stop Sequencer

This block produces a family of divided clock levels from a single fast master clock and parks them in a fixed order when a stop is requested. It keeps a free-running PCI-rate reference, a bank of PCI-rate outputs that can be stopped, and one differential SRC pair that runs at three times the PCI rate and can also be stopped. All outputs are registers clocked by the master clock, so every level change falls on a master-clock edge.

A stop comes from either an active-low pin, which is synchronised into the master domain first, or a configuration bit. The request is looked at only where the reference rises. Once a stop is taken, the stoppable PCI-rate outputs finish their high phase and hold low. The SRC pair then holds true-high and complement-low at its next rising edge, or floats when the float-select input is set. A request that is found released at a later reference rising edge restarts everything on a phase boundary. Per-output free-run inputs exempt an output from both stop sources.

The sequencer state machine has four states. `ST_RUN` is normal running. `ST_DRAIN` means a stop has been taken and the PCI-rate outputs are finishing their high phase. `ST_SRC_WAIT` means the PCI-rate outputs are parked and the SRC pair is waiting for its rising edge. `ST_PARKED` means everything stoppable is parked. Its transitions are:
- take-stop: `ST_RUN` to `ST_DRAIN`, at a reference rise with the request active.
- pci-parked: `ST_DRAIN` to `ST_SRC_WAIT`, at the reference fall.
- src-parked: `ST_SRC_WAIT` to `ST_PARKED`, at the next SRC rise.
- resume: `ST_PARKED` to `ST_RUN`, at a reference rise with the request inactive.

Top module: `clkstop_sequencer`

## Requirements
- R1: While reset is held, `pci_ref_o`, every `pci_o` bit and `src_p_o` are 0, `src_n_o` is 1 and `src_oe_o` is 1.
- R2: With `SRC_HALF` = H master cycles, the reference has a period of 6H cycles. Counting cycles from the release of reset, the reference is low for phase positions 0 to 3H-1 and high for 3H to 6H-1. A running `src_p_o` is high exactly when (position / H) is odd, and a running `src_n_o` is always its inverse.
- R3: The effective request is the pin after a two-flop synchroniser being low, OR `stop_reg_i` being 1. It is acted on only at the cycle where the reference rises. A pin pulse that lies completely between two reference rises has no effect.
- R4: After a stop is taken, every stoppable `pci_o` bit completes its current high phase, goes low at the next reference fall, and stays low.
- R5: A stoppable SRC pair parks only after the PCI-rate outputs have parked, at the first SRC rising position after that. It then holds `src_p_o`=1 and `src_n_o`=0.
- R6: When `src_float_i` is 1 and the SRC pair is parked, `src_oe_o` is 0. Otherwise `src_oe_o` is 1.
- R7: A `pci_o` bit whose `free_pci_i` bit is 1, and the SRC pair when `free_src_i` is 1, keep toggling and ignore both stop sources.
- R8: A released request that is seen at a reference rise restarts all parked outputs in that same cycle. No high or low run is then shorter than 3H cycles on `pci_o`, or shorter than H cycles on `src_p_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst_n | input | 1 | asynchronous active-low reset |
| stop_n_i | input | 1 | active-low stop pin, asynchronous |
| stop_reg_i | input | 1 | configuration stop bit, active high |
| free_pci_i | input | N_PCI | per-output free-run select for the PCI-rate bank |
| free_src_i | input | 1 | free-run select for the SRC pair |
| src_float_i | input | 1 | float the parked SRC pair instead of holding it |
| pci_ref_o | output | 1 | free-running PCI-rate reference |
| pci_o | output | N_PCI | stoppable PCI-rate outputs |
| src_p_o | output | 1 | SRC true output |
| src_n_o | output | 1 | SRC complement output |
| src_oe_o | output | 1 | SRC pair output enable |

## Verification
The embedded assertions check several properties on every cycle. The SRC pair is always complementary. A disabled SRC output is always held at its parked levels. The PCI bank changes level only when the reference changes. The state machine leaves `ST_RUN` only at a reference rise with the request active, and it enters `ST_PARKED` only from `ST_SRC_WAIT`. The ordering and timing of each park and resume depend on where in the phase a request arrives. The two-flop latency of the pin, the rejection of short pin pulses and the minimum run lengths after a restart are visible only when the bench's reference model is compared against every output on each cycle across the scenarios.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_DRAIN    = 2'd1,
        ST_SRC_WAIT = 2'd2,
        ST_PARKED   = 2'd3
    } stop_state_e;
endpackage

// File: rtl/clkstop_phase.sv
// Shared phase counter: one reference period spans six SRC half-periods.
// All strobes describe the position the counter moves to on the coming edge.
module clkstop_phase #(
    parameter int SRC_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic ref_nx,
    output logic src_nx,
    output logic ref_rise_nx,
    output logic ref_fall_nx,
    output logic src_rise_nx
);
    localparam int PERIOD   = 6 * SRC_HALF;
    localparam int CW       = $clog2(PERIOD);
    localparam int REF_RISE = 3 * SRC_HALF;
    localparam int SRC_PER  = 2 * SRC_HALF;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nx;
    int            src_pos;

    always_comb begin
        cnt_nx      = (cnt_q == CW'(PERIOD - 1)) ? '0 : cnt_q + 1'b1;
        src_pos     = int'(cnt_nx) % SRC_PER;
        ref_nx      = (cnt_nx >= CW'(REF_RISE));
        ref_rise_nx = (cnt_nx == CW'(REF_RISE));
        ref_fall_nx = (cnt_nx == '0);
        src_nx      = (src_pos >= SRC_HALF);
        src_rise_nx = (src_pos == SRC_HALF);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nx;
    end
endmodule

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '1;
                else        sh_q <= d_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '1;
                else        sh_q <= {sh_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/clkstop_fsm.sv
module clkstop_fsm
    import clkstop_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_i,
    input  logic        ref_rise_nx,
    input  logic        ref_fall_nx,
    input  logic        src_rise_nx,
    output stop_state_e state_q,
    output stop_state_e state_nx
);
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_RUN:      if (ref_rise_nx && req_i)  state_nx = ST_DRAIN;
            ST_DRAIN:    if (ref_fall_nx)           state_nx = ST_SRC_WAIT;
            ST_SRC_WAIT: if (src_rise_nx)           state_nx = ST_PARKED;
            ST_PARKED:   if (ref_rise_nx && !req_i) state_nx = ST_RUN;
            default:                                state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_nx;
    end

    // R3
    take_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN && $past(state_q) == ST_RUN) |-> $past(ref_rise_nx && req_i));

    // R5
    park_after_pci_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PARKED && $past(state_q) != ST_PARKED) |-> $past(state_q) == ST_SRC_WAIT);
endmodule

// File: rtl/clkstop_sequencer.sv
module clkstop_sequencer
    import clkstop_pkg::*;
#(
    parameter int N_PCI       = 4,
    parameter int SRC_HALF    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_n_i,
    input  logic             stop_reg_i,
    input  logic [N_PCI-1:0] free_pci_i,
    input  logic             free_src_i,
    input  logic             src_float_i,
    output logic             pci_ref_o,
    output logic [N_PCI-1:0] pci_o,
    output logic             src_p_o,
    output logic             src_n_o,
    output logic             src_oe_o
);
    logic        ref_nx, src_nx, ref_rise_nx, ref_fall_nx, src_rise_nx;
    logic        pin_sync;
    logic        req;
    logic        pci_en_nx, src_run_nx;
    stop_state_e state_q, state_nx;

    clkstop_phase #(.SRC_HALF(SRC_HALF)) u_phase (
        .clk(clk), .rst_n(rst_n),
        .ref_nx(ref_nx), .src_nx(src_nx),
        .ref_rise_nx(ref_rise_nx), .ref_fall_nx(ref_fall_nx),
        .src_rise_nx(src_rise_nx)
    );

    clkstop_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(stop_n_i), .q_o(pin_sync)
    );

    assign req = !pin_sync || stop_reg_i;

    clkstop_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req_i(req),
        .ref_rise_nx(ref_rise_nx), .ref_fall_nx(ref_fall_nx),
        .src_rise_nx(src_rise_nx),
        .state_q(state_q), .state_nx(state_nx)
    );

    always_comb begin
        pci_en_nx  = (state_nx == ST_RUN) || (state_nx == ST_DRAIN);
        src_run_nx = free_src_i || (state_nx != ST_PARKED);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pci_ref_o <= 1'b0;
            pci_o     <= '0;
            src_p_o   <= 1'b0;
            src_n_o   <= 1'b1;
            src_oe_o  <= 1'b1;
        end else begin
            pci_ref_o <= ref_nx;
            pci_o     <= {N_PCI{ref_nx}} & (free_pci_i | {N_PCI{pci_en_nx}});
            src_p_o   <= src_run_nx ? src_nx  : 1'b1;
            src_n_o   <= src_run_nx ? !src_nx : 1'b0;
            src_oe_o  <= src_run_nx || !src_float_i;
        end
    end

    // R2
    src_pair_compl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_p_o != src_n_o);

    // R6
    float_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !src_oe_o |-> (src_p_o && !src_n_o));

    // R8
    pci_moves_with_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(pci_o) && $stable(free_pci_i)) |-> !$stable(pci_ref_o));

    // R4
    parked_pci_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PARKED && $stable(free_pci_i)) |-> ((pci_o & ~free_pci_i) == '0));
endmodule

// File: tb/clkstop_sequencer_bench.sv
module clkstop_sequencer_bench;
    localparam int N = 4;
    localparam int H = 2;
    localparam int P = 6 * H;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         stop_n = 1'b1;
    logic         stop_reg = 1'b0;
    logic [N-1:0] free_pci = '0;
    logic         free_src = 1'b0;
    logic         src_float = 1'b0;
    logic         pci_ref;
    logic [N-1:0] pci;
    logic         src_p, src_n, src_oe;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model state
    int m_cnt, m_state;
    bit m_s1, m_s2;
    bit e_ref, e_p, e_n, e_oe;
    bit [N-1:0] e_pci;
    int run_pci, run_src;
    bit last_pci, last_src;

    always #4 clk = !clk;

    clkstop_sequencer #(.N_PCI(N), .SRC_HALF(H), .SYNC_STAGES(2)) u_clkstop_sequencer (
        .clk(clk), .rst_n(rst_n), .stop_n_i(stop_n), .stop_reg_i(stop_reg),
        .free_pci_i(free_pci), .free_src_i(free_src), .src_float_i(src_float),
        .pci_ref_o(pci_ref), .pci_o(pci), .src_p_o(src_p), .src_n_o(src_n),
        .src_oe_o(src_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_step();
        int  cn;
        bit  rq, lr, ls, srun;
        cn = (m_cnt + 1) % P;
        rq = !m_s2 || stop_reg;
        case (m_state)
            0: if (cn == 3 * H && rq) m_state = 1;
            1: if (cn == 0) m_state = 2;
            2: if (cn % (2 * H) == H) m_state = 3;
            default: if (cn == 3 * H && !rq) m_state = 0;
        endcase
        m_s2 = m_s1;
        m_s1 = stop_n;
        m_cnt = cn;
        lr = (cn >= 3 * H);
        ls = ((cn / H) % 2) == 1;
        e_ref = lr;
        for (int i = 0; i < N; i++) e_pci[i] = lr && (free_pci[i] || m_state <= 1);
        srun = free_src || (m_state != 3);
        e_p  = srun ? ls : 1'b1;
        e_n  = srun ? !ls : 1'b0;
        e_oe = srun || !src_float;
    endtask

    task automatic cycle();
        @(negedge clk);
        model_step();
        check(pci_ref == e_ref, "R2 ref", pci_ref, e_ref);
        check(pci == e_pci, "R4/R7 pci", pci, e_pci);
        check({src_p, src_n} == {e_p, e_n}, "R5 src pair", {src_p, src_n}, {e_p, e_n});
        check(src_oe == e_oe, "R6 oe", src_oe, e_oe);
        if (pci[0] != last_pci) begin
            check(run_pci >= 3 * H, "R8 pci run", run_pci, 3 * H);
            run_pci = 1;
        end else run_pci++;
        if (src_p != last_src) begin
            check(run_src >= H, "R8 src run", run_src, H);
            run_src = 1;
        end else run_src++;
        last_pci = pci[0];
        last_src = src_p;
    endtask

    task automatic wait_ref_rise();
        bit prev;
        prev = pci_ref;
        for (int k = 0; k < 2 * P; k++) begin
            cycle();
            if (pci_ref && !prev) return;
            prev = pci_ref;
        end
    endtask

    task automatic count_toggles(input int n, output int t0, output int t1, output int ts);
        bit a, b, c;
        t0 = 0; t1 = 0; ts = 0;
        a = pci[0]; b = pci[1]; c = src_p;
        for (int k = 0; k < n; k++) begin
            cycle();
            if (pci[0] != a) t0++;
            if (pci[1] != b) t1++;
            if (src_p != c) ts++;
            a = pci[0]; b = pci[1]; c = src_p;
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        int t0, t1, ts;
        repeat (3) @(negedge clk);
        // R1 reset state
        check({pci_ref, pci, src_p, src_n, src_oe} == {1'b0, {N{1'b0}}, 1'b0, 1'b1, 1'b1},
              "R1 reset", {pci_ref, pci, src_p, src_n, src_oe}, {1'b0, {N{1'b0}}, 3'b011});
        m_cnt = 0; m_state = 0; m_s1 = 1; m_s2 = 1;
        run_pci = 100; run_src = 100; last_pci = 0; last_src = 0;
        rst_n = 1'b1;
        repeat (30) cycle();

        // R3 R4 R5: pin stop at an arbitrary phase
        repeat (5) cycle();
        stop_n = 1'b0;
        repeat (40) cycle();
        check(pci == '0, "R4 parked low", pci, 0);
        check({src_p, src_n, src_oe} == 3'b101, "R5 parked high/low", {src_p, src_n, src_oe}, 3'b101);
        stop_n = 1'b1;
        repeat (10) cycle();
        // R8 resumed outputs toggle again
        count_toggles(3 * P, t0, t1, ts);
        check(t0 > 0 && ts > 0, "R8 resume", t0 + ts, 1);

        // R3 short pin pulse right after a reference rise is ignored
        wait_ref_rise();
        stop_n = 1'b0;
        cycle(); cycle();
        stop_n = 1'b1;
        count_toggles(3 * P, t0, t1, ts);
        check(t0 >= 4, "R3 short pulse ignored", t0, 4);

        // R3 register stop bit alone; R6 float
        src_float = 1'b1;
        stop_reg = 1'b1;
        repeat (3 * P) cycle();
        check(src_oe == 1'b0, "R6 float when parked", src_oe, 0);
        check(pci == '0, "R3 register stop", pci, 0);
        stop_reg = 1'b0;
        repeat (2 * P) cycle();
        check(src_oe == 1'b1, "R6 oe restored", src_oe, 1);
        src_float = 1'b0;

        // R7 free-running bit 1 and SRC while stopped
        free_pci = 4'b0010;
        free_src = 1'b1;
        repeat (P) cycle();
        stop_n = 1'b0;
        repeat (2 * P) cycle();
        count_toggles(3 * P, t0, t1, ts);
        check(t1 >= 4 && ts >= 6, "R7 free outputs toggle", t1 + ts, 10);
        check(t0 == 0, "R7 stoppable bit parked", t0, 0);
        check(src_oe == 1'b1, "R7 free src enabled", src_oe, 1);
        stop_n = 1'b1;
        repeat (3 * P) cycle();
        free_pci = '0;
        free_src = 1'b0;
        repeat (2 * P) cycle();

        // stop from both sources overlapping
        stop_reg = 1'b1;
        repeat (7) cycle();
        stop_n = 1'b0;
        repeat (2 * P) cycle();
        stop_reg = 1'b0;
        repeat (2 * P) cycle();
        check(pci == '0, "R3 pin still holds stop", pci, 0);
        stop_n = 1'b1;
        repeat (3 * P) cycle();

        done = 1;
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            finish_run();
        end
    end
endmodule